// File: doc/BRIEF.md
# Serial Word Transmitter/Receiver with Internal Loopback

This block is the data path of a synchronous serial port. A host writes a word into a transmit holding register. When the transmitter is idle, the word moves into a shift register. A one-bit-period frame-sync pulse marks the start of the frame, and the bits leave on a bit clock that the block derives from the system clock. On the receive side, the block watches a bit clock, a frame-sync line and a data line. It assembles the word after the frame sync and parks it in a receive buffer that the host reads.

The following are configuration inputs: the element length, the bit order, the edge on which transmit data changes, the edge on which receive data is sampled, and the polarity of each frame sync. They are expected to be changed only while both directions are idle. A loopback input routes the transmit clock, frame sync and data into the receiver in place of the receive pins, so a written word can be read back. All logic runs on the system clock. The receive pins are treated as signals synchronous to it and are sampled once per system clock.

Top module: `sport_loop`

## Requirements
- R1: `len_sel` selects the element length. Codes 0, 1, 2, 3 and 4 give 8, 12, 16, 20 and 24 bits. Codes 5, 6 and 7 give 32 bits. A received word shorter than 32 bits sits in the low bits of `rd_data`, and the upper bits are zero.
- R2: With `lsb_first` low, bits are sent and assembled MSB first. With `lsb_first` high and a 32-bit length, bit 0 goes out first, and the receiver restores the original order. With any other length, `lsb_first` has no effect.
- R3: `tx_bclk` is high for `DIV_HALF` system clocks and low for `DIV_HALF` system clocks, and it is 0 in reset. `tx_dat` changes only in the same cycle as a transition of `tx_bclk`. That transition is falling when `tx_fall` is 1 and rising when it is 0.
- R4: The receiver samples `rx_fs` and `rx_dat` when it sees a transition of its bit clock. That transition is rising when `rx_rise` is 1 and falling when it is 0.
- R5: `tx_fs` is high when active if `tx_fs_low` is 0, and low when active if `tx_fs_low` is 1. `rx_fs_low` defines the active level of the receive frame sync in the same way.
- R6: A copy from the holding register into the shift register happens on a data edge while the shifter is idle. The copy makes `tx_fs` active for exactly one bit period, with `tx_dat` at 0. The first data bit appears on the next data edge.
- R7: `tx_rdy` is 1 while the holding register is empty. It goes to 0 in the cycle after `wr_en`, and returns to 1 in the cycle of the copy. A write while it is 0 replaces the held word.
- R8: `rx_rdy` rises one cycle after the last bit of a frame is sampled. At that point `rd_data` holds the new word and stays stable until the next word completes. `rd_en` clears `rx_rdy`. If a word completes in the same cycle as `rd_en`, `rx_rdy` stays 1 with the new word.
- R9: With `loopback` at 1, the receiver takes `tx_bclk`, `tx_fs` and `tx_dat` and ignores `rx_bclk`, `rx_fs` and `rx_dat`. A written word is returned in `rd_data`, masked to the element length.
- R10: While `rst_n` is low, `tx_rdy` is 1, `rx_rdy` is 0, `tx_dat` is 0, `rd_data` is 0 and `tx_fs` is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| len_sel | input | 3 | Element length code |
| lsb_first | input | 1 | Bit-reversed order for 32-bit words |
| tx_fall | input | 1 | Transmit data changes on falling bit-clock edge |
| rx_rise | input | 1 | Receiver samples on rising bit-clock edge |
| tx_fs_low | input | 1 | Transmit frame sync active low |
| rx_fs_low | input | 1 | Receive frame sync active low |
| loopback | input | 1 | Route transmitter into receiver |
| wr_en | input | 1 | Write `wr_data` into the holding register |
| wr_data | input | 32 | Word to transmit |
| tx_rdy | output | 1 | Holding register empty |
| rd_en | input | 1 | Acknowledge the receive buffer |
| rd_data | output | 32 | Receive buffer |
| rx_rdy | output | 1 | Receive buffer holds an unread word |
| tx_bclk | output | 1 | Transmit bit clock |
| tx_fs | output | 1 | Transmit frame sync |
| tx_dat | output | 1 | Transmit serial data |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync |
| rx_dat | input | 1 | Receive serial data |

## Verification
The completion of a received word and a host read of the receive buffer can fall in the same system clock. The bench provokes this by driving the receive pins itself. On the sampling edge of the last bit of a second frame, it asserts `rd_en` while the first word is still unread. The outcome is judged correct only if `rx_rdy` is still 1 afterwards and `rd_data` holds the second word. A following read on its own must then clear `rx_rdy`.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 6;

  function automatic logic [LEN_W-1:0] elem_len(input logic [2:0] sel);
    case (sel)
      3'd0:    return LEN_W'(8);
      3'd1:    return LEN_W'(12);
      3'd2:    return LEN_W'(16);
      3'd3:    return LEN_W'(20);
      3'd4:    return LEN_W'(24);
      default: return LEN_W'(32);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] bit_rev(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
    return r;
  endfunction

  // reversal only applies to full-width words
  function automatic logic rev_on(input logic lsb, input logic [LEN_W-1:0] len);
    return lsb && (len == LEN_W'(WORD_W));
  endfunction

  // place a len-bit word at the top of the shifter so bit 31 leaves first
  function automatic logic [WORD_W-1:0] msb_align(input logic [WORD_W-1:0] w,
                                                  input logic [LEN_W-1:0] len);
    return w << (LEN_W'(WORD_W) - len);
  endfunction
endpackage

// File: rtl/sport_clkgen.sv
module sport_clkgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic bclk,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = $clog2(DIV_HALF) + 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = (cnt == CW'(DIV_HALF - 1));
  assign rise_ev = wrap & ~bclk;
  assign fall_ev = wrap & bclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/sport_tx.sv
module sport_tx
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_ev,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [LEN_W-1:0]  len,
  input  logic              rev,
  output logic              tx_rdy,
  output logic              fs_act,
  output logic              dat,
  output logic              copy_ev
);
  logic [WORD_W-1:0] hold_q;
  logic              hold_full;
  logic [WORD_W-1:0] shift_q;
  logic [LEN_W-1:0]  bits_left;
  logic              shift_ev;

  assign copy_ev  = drive_ev && (bits_left == '0) && hold_full;
  assign shift_ev = drive_ev && (bits_left != '0);
  assign tx_rdy   = ~hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (wr_en) begin
      hold_q    <= wr_data;
      hold_full <= 1'b1;
    end else if (copy_ev) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q   <= '0;
      bits_left <= '0;
      fs_act    <= 1'b0;
      dat       <= 1'b0;
    end else if (copy_ev) begin
      shift_q   <= rev ? bit_rev(hold_q) : msb_align(hold_q, len);
      bits_left <= len;
      fs_act    <= 1'b1;
      dat       <= 1'b0;
    end else if (shift_ev) begin
      dat       <= shift_q[WORD_W-1];
      shift_q   <= {shift_q[WORD_W-2:0], 1'b0};
      bits_left <= bits_left - LEN_W'(1);
      fs_act    <= 1'b0;
    end else if (drive_ev) begin
      fs_act <= 1'b0;
    end
  end
endmodule

// File: rtl/sport_rx.sv
module sport_rx
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_in,
  input  logic              sample_rise,
  input  logic              fs_in,
  input  logic              dat_in,
  input  logic [LEN_W-1:0]  len,
  input  logic              rev,
  input  logic              rd_en,
  output logic              rx_rdy,
  output logic [WORD_W-1:0] rd_data,
  output logic              done_ev
);
  logic              bclk_q;
  logic              sample_ev;
  logic [LEN_W-1:0]  cnt;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] acc_nxt;

  assign sample_ev = sample_rise ? (bclk_in & ~bclk_q) : (~bclk_in & bclk_q);
  assign acc_nxt   = {acc[WORD_W-2:0], dat_in};
  assign done_ev   = sample_ev && !fs_in && (cnt == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
    end else begin
      bclk_q <= bclk_in;
      if (sample_ev) begin
        if (fs_in) begin
          cnt <= len;
          acc <= '0;
        end else if (cnt != '0) begin
          cnt <= cnt - LEN_W'(1);
          acc <= acc_nxt;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rx_rdy  <= 1'b0;
    end else if (done_ev) begin
      rd_data <= rev ? bit_rev(acc_nxt) : acc_nxt;
      rx_rdy  <= 1'b1;
    end else if (rd_en) begin
      rx_rdy <= 1'b0;
    end
  end
endmodule

// File: rtl/sport_loop.sv
module sport_loop
  import sport_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        len_sel,
  input  logic              lsb_first,
  input  logic              tx_fall,
  input  logic              rx_rise,
  input  logic              tx_fs_low,
  input  logic              rx_fs_low,
  input  logic              loopback,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              tx_rdy,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rx_rdy,
  output logic              tx_bclk,
  output logic              tx_fs,
  output logic              tx_dat,
  input  logic              rx_bclk,
  input  logic              rx_fs,
  input  logic              rx_dat
);
  logic [LEN_W-1:0] len;
  logic             rev;
  logic             rise_ev, fall_ev;
  logic             drive_ev;
  logic             copy_ev;
  logic             done_ev;
  logic             fs_tx_act;
  logic             rx_clk_sel, rx_fs_lvl, rx_dat_sel, rx_fs_act;

  assign len      = elem_len(len_sel);
  assign rev      = rev_on(lsb_first, len);
  assign drive_ev = tx_fall ? fall_ev : rise_ev;
  assign tx_fs    = fs_tx_act ^ tx_fs_low;

  assign rx_clk_sel = loopback ? tx_bclk : rx_bclk;
  assign rx_fs_lvl  = loopback ? tx_fs   : rx_fs;
  assign rx_dat_sel = loopback ? tx_dat  : rx_dat;
  assign rx_fs_act  = rx_fs_lvl ^ rx_fs_low;

  sport_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .bclk(tx_bclk),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  sport_tx u_tx (
    .clk(clk), .rst_n(rst_n), .drive_ev(drive_ev),
    .wr_en(wr_en), .wr_data(wr_data), .len(len), .rev(rev),
    .tx_rdy(tx_rdy), .fs_act(fs_tx_act), .dat(tx_dat), .copy_ev(copy_ev)
  );

  sport_rx u_rx (
    .clk(clk), .rst_n(rst_n), .bclk_in(rx_clk_sel), .sample_rise(rx_rise),
    .fs_in(rx_fs_act), .dat_in(rx_dat_sel), .len(len), .rev(rev),
    .rd_en(rd_en), .rx_rdy(rx_rdy), .rd_data(rd_data), .done_ev(done_ev)
  );
endmodule

// File: rtl/sport_loop_chk.sv
module sport_loop_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        tx_rdy,
  input logic        rx_rdy,
  input logic        tx_fs,
  input logic        tx_fs_low,
  input logic        tx_dat,
  input logic [31:0] rd_data,
  input logic        copy_ev,
  input logic        drive_ev,
  input logic        done_ev,
  input logic        fs_tx_act
);
  p_wr_clears_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_rdy);
  p_copy_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_ev && !wr_en) |=> tx_rdy);
  p_copy_fs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    copy_ev |=> (tx_fs != tx_fs_low));
  p_fs_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_tx_act && drive_ev) |=> (tx_fs == tx_fs_low));
  p_fs_dat_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fs_tx_act |-> !tx_dat);
  p_dat_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_ev |=> $stable(tx_dat));
  p_done_sets_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> rx_rdy);
  p_rd_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !done_ev) |=> !rx_rdy);
  p_buf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_ev |=> $stable(rd_data));
endmodule

bind sport_loop sport_loop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .tx_fs(tx_fs), .tx_fs_low(tx_fs_low),
  .tx_dat(tx_dat), .rd_data(rd_data), .copy_ev(copy_ev),
  .drive_ev(drive_ev), .done_ev(done_ev), .fs_tx_act(fs_tx_act)
);

// File: tb/sport_loop_test.sv
module sport_loop_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  len_sel = 3'd5;
  logic        lsb_first = 1'b0, tx_fall = 1'b0, rx_rise = 1'b0;
  logic        tx_fs_low = 1'b0, rx_fs_low = 1'b0, loopback = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rx_bclk = 1'b0, rx_fs = 1'b0, rx_dat = 1'b0;
  logic        tx_rdy, rx_rdy, tx_bclk, tx_fs, tx_dat;
  logic [31:0] rd_data;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;
  logic        mon_on = 1'b0;
  logic        pb = 1'b0, pd = 1'b0;

  always #4 clk = ~clk;

  sport_loop #(.DIV_HALF(2)) uut (
    .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .lsb_first(lsb_first),
    .tx_fall(tx_fall), .rx_rise(rx_rise), .tx_fs_low(tx_fs_low),
    .rx_fs_low(rx_fs_low), .loopback(loopback), .wr_en(wr_en),
    .wr_data(wr_data), .tx_rdy(tx_rdy), .rd_en(rd_en), .rd_data(rd_data),
    .rx_rdy(rx_rdy), .tx_bclk(tx_bclk), .tx_fs(tx_fs), .tx_dat(tx_dat),
    .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_dat(rx_dat)
  );

  function automatic int blen(input logic [2:0] s);
    return (s <= 3'd4) ? 8 + 4 * int'(s) : 32;
  endfunction

  function automatic logic [31:0] lmask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // R3: data may only move with the configured transmit clock transition
  always @(negedge clk) begin
    if (mon_on && (tx_dat !== pd)) begin
      checks++;
      if (!(tx_fall ? (pb === 1'b1 && tx_bclk === 1'b0)
                    : (pb === 1'b0 && tx_bclk === 1'b1))) begin
        errors++;
        $display("FAIL R3 tx_dat moved with bclk %b->%b expected edge fall=%b", pb, tx_bclk, tx_fall);
      end
    end
    pb <= tx_bclk;
    pd <= tx_dat;
  end

  task automatic wait_rx(input bit noise);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (noise) rx_bclk = ~rx_bclk;
      if (rx_rdy) break;
    end
  endtask

  task automatic do_read();
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic wait_drive(input logic txf);
    logic p;
    p = tx_bclk;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tx_bclk !== p && tx_bclk === ~txf) break;
      p = tx_bclk;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 tx_rdy", 32'(tx_rdy), 32'd1);
    chk("R10 rx_rdy", 32'(rx_rdy), 32'd0);
    chk("R10 tx_dat", 32'(tx_dat), 32'd0);
    chk("R10 tx_fs idle", 32'(tx_fs), 32'(tx_fs_low));
    chk("R10 rd_data", rd_data, 32'd0);
  endtask

  task automatic t_loop(input logic [2:0] sel, input logic lsb, input logic txf,
                        input logic fsl, input logic [31:0] w, input bit noise,
                        input string tag);
    logic [31:0] exp;
    @(negedge clk);
    len_sel = sel; lsb_first = lsb; tx_fall = txf; rx_rise = txf;
    tx_fs_low = fsl; rx_fs_low = fsl; loopback = 1'b1;
    if (noise) begin rx_fs = ~fsl; rx_dat = 1'b1; end
    @(negedge clk);
    chk("R5 tx_fs idle level", 32'(tx_fs), 32'(fsl));
    mon_on = 1'b1;
    wr_en = 1'b1; wr_data = w;
    @(negedge clk) wr_en = 1'b0;
    chk("R7 tx_rdy after write", 32'(tx_rdy), 32'd0);
    wait_rx(noise);
    exp = w & lmask(blen(sel));
    chk("R8 rx_rdy set", 32'(rx_rdy), 32'd1);
    chk(tag, rd_data, exp);
    do_read();
    chk("R8 rx_rdy cleared by read", 32'(rx_rdy), 32'd0);
    mon_on = 1'b0;
    rx_bclk = 1'b0; rx_fs = fsl; rx_dat = 1'b0;
  endtask

  task automatic t_frame(input logic [2:0] sel, input logic lsb, input logic txf,
                         input logic [31:0] w);
    int n;
    logic expb;
    n = blen(sel);
    @(negedge clk);
    len_sel = sel; lsb_first = lsb; tx_fall = txf; rx_rise = txf;
    tx_fs_low = 1'b0; rx_fs_low = 1'b0; loopback = 1'b1;
    wr_en = 1'b1; wr_data = w;
    @(negedge clk) wr_en = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (tx_fs === 1'b1) break;
      @(negedge clk);
    end
    chk("R6 frame sync seen", 32'(tx_fs), 32'd1);
    chk("R7 tx_rdy returns with copy", 32'(tx_rdy), 32'd1);
    chk("R6 tx_dat low during sync", 32'(tx_dat), 32'd0);
    for (int i = 0; i < n; i++) begin
      wait_drive(txf);
      if (i == 0) chk("R6 sync lasts one bit", 32'(tx_fs), 32'd0);
      expb = (lsb && n == 32) ? w[i] : w[n-1-i];
      chk($sformatf("R2 serial bit %0d", i), 32'(tx_dat), 32'(expb));
    end
    wait_rx(1'b0);
    chk("R9 frame returned", rd_data, w & lmask(n));
    do_read();
  endtask

  task automatic slot(input logic a, input logic fsv, input logic d, input logic rd);
    @(negedge clk);
    rx_bclk = ~a; rx_fs = fsv; rx_dat = d;
    @(negedge clk);
    @(negedge clk);
    rx_bclk = a; rd_en = rd;
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic send_ext(input int n, input logic a, input logic fsl,
                          input logic [31:0] w, input logic rd_last);
    slot(a, ~fsl, 1'b0, 1'b0);
    for (int i = 0; i < n; i++)
      slot(a, fsl, w[n-1-i], rd_last && (i == n - 1));
    rx_fs = fsl;
  endtask

  task automatic t_ext(input logic [2:0] sel, input logic rise, input logic fsl,
                       input logic [31:0] w1, input logic [31:0] w2);
    int n;
    n = blen(sel);
    @(negedge clk);
    loopback = 1'b0; len_sel = sel; lsb_first = 1'b0;
    rx_rise = rise; rx_fs_low = fsl; rx_fs = fsl;
    send_ext(n, rise, fsl, w1, 1'b0);
    chk("R4 word on selected edge", 32'(rx_rdy), 32'd1);
    chk("R1 R4 R5 zero-filled word", rd_data, w1 & lmask(n));
    send_ext(n, rise, fsl, w2, 1'b1);
    chk("R8 completion beats read", 32'(rx_rdy), 32'd1);
    chk("R8 new word on collision", rd_data, w2 & lmask(n));
    do_read();
    chk("R8 read alone clears", 32'(rx_rdy), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_loop(3'd5, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF, 1'b0, "R1 R9 32-bit msb first");
    t_loop(3'd5, 1'b1, 1'b1, 1'b0, 32'h1234_5678, 1'b1, "R2 R9 lsb-first with pin noise");
    t_loop(3'd2, 1'b0, 1'b0, 1'b1, 32'hCAFE_1234, 1'b0, "R1 R5 16-bit active-low sync");
    t_loop(3'd3, 1'b1, 1'b0, 1'b0, 32'hABCD_E987, 1'b0, "R2 order flag ignored at 20 bits");
    t_loop(3'd7, 1'b0, 1'b1, 1'b0, 32'h8000_0001, 1'b0, "R1 code 7 is 32 bits");
    t_loop(3'd0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FF5A, 1'b0, "R1 8-bit");
    t_frame(3'd0, 1'b0, 1'b0, 32'h0000_00A5);
    t_frame(3'd5, 1'b1, 1'b1, 32'h0000_000B);
    t_ext(3'd1, 1'b1, 1'b0, 32'hFFFF_FABC, 32'hFFFF_F123);
    t_ext(3'd4, 1'b0, 1'b1, 32'h5512_3456, 32'h00FE_DCBA);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule